// File: doc/BRIEF.md
# Store Buffer with Slice-Matched Load Forwarding

This block sits between a processor's load/store unit and external memory. Stores are accepted into a small queue, each slot holding the full address and the data word, so the processor can continue without waiting for the memory bus. The queue empties to memory strictly oldest-first through a valid/ready write port.

Each load compares a narrow slice of its address, bits [9:2], against every occupied slot in parallel. If the youngest slot whose slice matches also matches on the full address, its data goes straight back to the processor and memory is not touched. A slice match with a different full address may be a false hit, so the load waits. A load with no usable match is sent to memory only after every queued store has been written. The result is that buffered stores always reach memory before any read.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the queue is empty: `mem_wr_valid` is 0, `st_ready` is 1 while `ld_valid` is 0, and `ld_done` is 0 while `ld_valid` is 0.
- R2: A store is taken on a clock edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while `ld_valid` is 1, and a store offered while `st_ready` is 0 never reaches memory.
- R3: Whenever the queue holds at least one entry, `mem_wr_valid` is 1 and the write port shows the oldest entry. That entry stays unchanged until a clock edge with `mem_wr_ready` high. Entries reach memory in the order they were accepted, with their address and data unaltered.
- R4: A load is forwarded when the youngest slot whose address bits [9:2] equal the load's bits [9:2] also equals it on all 32 bits. In the same cycle `ld_done` and `ld_fwd` are 1, `ld_data` is that slot's data, and `mem_rd_req` is 0.
- R5: When several slots match the load address, the most recently accepted one supplies the data.
- R6: When the youngest slice-matching slot differs from the load in any other address bit, the load gets no response and makes no memory request while the queue is non-empty. After draining, it is served from memory and returns the value memory then holds.
- R7: A load that is not forwarded raises `mem_rd_req`, with `mem_rd_addr` equal to `ld_addr`, only once the queue is empty. It completes in the cycle `mem_rd_ack` is 1, with `ld_done` 1, `ld_fwd` 0 and `ld_data` equal to `mem_rd_data`.
- R8: `mem_rd_req` and `mem_wr_valid` are never 1 in the same cycle.
- R9: The queue accepts exactly DEPTH (8) stores while memory is not draining. After that, `st_ready` stays 0 until an entry leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_ready | output | 1 | Store will be taken this edge |
| ld_valid | input | 1 | Processor load request, held until `ld_done` |
| ld_addr | input | 32 | Load byte address |
| ld_done | output | 1 | Load completes this cycle |
| ld_fwd | output | 1 | Completed load was served from the queue |
| ld_data | output | 32 | Load result |
| mem_wr_valid | output | 1 | Oldest queued store offered to memory |
| mem_wr_addr | output | 32 | Address of the offered store |
| mem_wr_data | output | 32 | Data of the offered store |
| mem_wr_ready | input | 1 | Memory takes the offered store this edge |
| mem_rd_req | output | 1 | Memory read request for the current load |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_ack | input | 1 | Memory read data valid this cycle |
| mem_rd_data | input | 32 | Memory read data |

## Verification
The bench sweeps every queue slot as a forwarding source and every depth from two to eight for repeated stores to one address. A selector that picked the oldest match, or one that confused slot order, would return a stale word. It builds false hits that differ from a queued entry only in bit 10, including the case where an older entry matches exactly but a younger one only on the slice. A design that forwarded on the slice alone would return the wrong store's data, and one that read memory early would return the value from before the store. Filling the queue to its limit and then offering one more store shows up as an extra write in the drain order check if the full stall is wrong. Loads that have no match must not reach memory while a write is pending, and a design that lets them through would return the pre-store value.

// File: rtl/wbuf_pkg.sv
// Shared widths and the queue slot layout for the store buffer.
package wbuf_pkg;
    localparam int WB_AW = 32;
    localparam int WB_DW = 32;

    typedef struct packed {
        logic [WB_AW-1:0] addr;
        logic [WB_DW-1:0] data;
    } wb_entry_t;
endpackage

// File: rtl/wbuf_store.sv
// Collapsing store queue. Slot 0 always holds the oldest entry, and a
// higher index means a younger entry. Pops shift every slot down by
// one, and a push lands just above the youngest entry after that shift.
// Assumes pop is only requested when count is non-zero and push only
// when count is below DEPTH.
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  wb_entry_t             push_ent,
    input  logic                  pop,
    output wb_entry_t [DEPTH-1:0] ents,
    output logic [CW-1:0]         count
);
    wb_entry_t       slot_q [DEPTH];
    logic [CW-1:0]   wr_slot;

    // Target slot for an incoming store, after any simultaneous shift.
    assign wr_slot = pop ? count - 1'b1 : count;

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (push && !pop)   count <= count + 1'b1;
        else if (pop && !push)   count <= count - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        wb_entry_t shift_in;
        if (i == DEPTH - 1) begin : g_top
            assign shift_in = '0;
        end else begin : g_mid
            assign shift_in = slot_q[i+1];
        end

        // Slot register: load a new store, or take the neighbour above on a pop.
        always_ff @(posedge clk) begin
            if (!rst_n)                              slot_q[i] <= '0;
            else if (push && wr_slot == CW'(i))      slot_q[i] <= push_ent;
            else if (pop)                            slot_q[i] <= shift_in;
        end

        assign ents[i] = slot_q[i];
    end
endmodule

// File: rtl/wbuf_match.sv
// Parallel slice comparator. Every occupied slot compares address bits
// [SLICE_HI:SLICE_LO] against the load, and the youngest matching slot
// (the highest index) is selected. Reports whether that slot also
// matches on the full address. Assumes slot order as in wbuf_store.
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SLICE_LO = 2,
    parameter int SLICE_HI = 9,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  wb_entry_t [DEPTH-1:0] ents,
    input  logic [CW-1:0]         count,
    input  logic [WB_AW-1:0]      ld_addr,
    output logic                  any_hit,
    output logic                  exact,
    output logic [WB_DW-1:0]      sel_data
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // Slice compare of one occupied slot.
        assign hit_vec[i] = (CW'(i) < count) &&
            (ents[i].addr[SLICE_HI:SLICE_LO] == ld_addr[SLICE_HI:SLICE_LO]);
    end

    // Youngest-wins select: later indices override earlier ones.
    always_comb begin
        any_hit  = 1'b0;
        exact    = 1'b0;
        sel_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                any_hit  = 1'b1;
                exact    = (ents[i].addr == ld_addr);
                sel_data = ents[i].data;
            end
        end
    end
endmodule

// File: rtl/wbuf_fwd.sv
// Store buffer with slice-matched load forwarding. Stores are queued
// and drained oldest-first. A load is answered from the queue when its
// youngest slice match is an exact match. Otherwise it waits for the
// queue to empty, then reads memory. Assumes the processor holds
// ld_valid and ld_addr steady until ld_done. New stores are held off
// while a load is pending, which keeps program order.
module wbuf_fwd
    import wbuf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SLICE_LO = 2,
    parameter int SLICE_HI = 9,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [WB_AW-1:0] st_addr,
    input  logic [WB_DW-1:0] st_data,
    output logic             st_ready,
    input  logic             ld_valid,
    input  logic [WB_AW-1:0] ld_addr,
    output logic             ld_done,
    output logic             ld_fwd,
    output logic [WB_DW-1:0] ld_data,
    output logic             mem_wr_valid,
    output logic [WB_AW-1:0] mem_wr_addr,
    output logic [WB_DW-1:0] mem_wr_data,
    input  logic             mem_wr_ready,
    output logic             mem_rd_req,
    output logic [WB_AW-1:0] mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [WB_DW-1:0] mem_rd_data
);
    wb_entry_t [DEPTH-1:0] ents;
    logic [CW-1:0]         count;
    logic                  full, empty, push, pop;
    logic                  any_hit, exact, fwd;
    logic [WB_DW-1:0]      sel_data;

    // Queue state decode and edge handshakes.
    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign st_ready = !full && !ld_valid;
    assign push     = st_valid && st_ready;
    assign pop      = mem_wr_valid && mem_wr_ready;

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent ('{addr: st_addr, data: st_data}),
        .pop      (pop),
        .ents     (ents),
        .count    (count)
    );

    wbuf_match #(.DEPTH(DEPTH), .SLICE_LO(SLICE_LO), .SLICE_HI(SLICE_HI)) u_match (
        .ents     (ents),
        .count    (count),
        .ld_addr  (ld_addr),
        .any_hit  (any_hit),
        .exact    (exact),
        .sel_data (sel_data)
    );

    // Memory write port always presents the oldest slot.
    assign mem_wr_valid = !empty;
    assign mem_wr_addr  = ents[0].addr;
    assign mem_wr_data  = ents[0].data;

    // Load resolution: forward on an exact youngest match, else read after drain.
    assign fwd         = ld_valid && any_hit && exact;
    assign mem_rd_req  = ld_valid && empty;
    assign mem_rd_addr = ld_addr;
    assign ld_done     = fwd || (mem_rd_req && mem_rd_ack);
    assign ld_fwd      = fwd;
    assign ld_data     = fwd ? sel_data : mem_rd_data;
endmodule

// File: rtl/wbuf_fwd_chk.sv
// Port-level checker for wbuf_fwd. Keeps its own occupancy count from
// the push and pop handshakes it sees. Assumes nothing about internals.
module wbuf_fwd_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        st_valid,
    input logic        st_ready,
    input logic        ld_valid,
    input logic        ld_done,
    input logic        ld_fwd,
    input logic [31:0] ld_data,
    input logic        mem_wr_valid,
    input logic [31:0] mem_wr_addr,
    input logic [31:0] mem_wr_data,
    input logic        mem_wr_ready,
    input logic        mem_rd_req,
    input logic        mem_rd_ack,
    input logic [31:0] mem_rd_data
);
    int occ;

    // Shadow occupancy from observed handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= 0;
        else occ <= occ + int'(st_valid && st_ready) - int'(mem_wr_valid && mem_wr_ready);
    end

    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 0) |-> !mem_wr_valid);
    p_pending_shown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != 0) |-> mem_wr_valid);
    p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
        (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    p_load_blocks_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !st_ready);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (occ >= DEPTH) |-> !st_ready);
    p_fwd_skips_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> (ld_done && !mem_rd_req));
    p_mem_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && !ld_fwd) |-> (mem_rd_req && mem_rd_ack && ld_data == mem_rd_data));
    p_writes_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (!mem_wr_valid && occ == 0));
endmodule

bind wbuf_fwd wbuf_fwd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .ld_valid     (ld_valid),
    .ld_done      (ld_done),
    .ld_fwd       (ld_fwd),
    .ld_data      (ld_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ready (mem_wr_ready),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_ack   (mem_rd_ack),
    .mem_rd_data  (mem_rd_data)
);

// File: tb/wbuf_fwd_bench.sv
// Self-checking bench for wbuf_fwd: slot sweeps, youngest-match depth
// sweep, false hits, full stall and drain ordering against a bench memory.
module wbuf_fwd_bench;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        st_ready;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_done, ld_fwd;
    logic [31:0] ld_data;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic        wr_rdy = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        rd_ack = 1'b1;
    logic [31:0] mem_rd_data;

    logic [31:0] mem [1024];
    logic [31:0] exp_a [$];
    logic [31:0] exp_d [$];
    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign mem_rd_data = mem[mem_rd_addr[11:2]];

    wbuf_fwd #(.DEPTH(DEPTH)) u_wbuf_fwd (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_done(ld_done), .ld_fwd(ld_fwd),
        .ld_data(ld_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(wr_rdy),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(rd_ack),
        .mem_rd_data(mem_rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Bench memory: apply drained writes and check their order (R3, R2).
    always @(posedge clk) begin
        if (rst_n && mem_wr_valid && wr_rdy) begin
            if (exp_a.size() == 0) begin
                chk(1'b0, "R2 unexpected write", mem_wr_addr, 32'h0);
            end else begin
                chk(mem_wr_addr == exp_a[0], "R3 drain address", mem_wr_addr, exp_a[0]);
                chk(mem_wr_data == exp_d[0], "R3 drain data", mem_wr_data, exp_d[0]);
                void'(exp_a.pop_front());
                void'(exp_d.pop_front());
            end
            mem[mem_wr_addr[11:2]] <= mem_wr_data;
        end
    end

    task automatic push_st(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        chk(st_ready == 1'b1, "R2 store accepted", 32'(st_ready), 32'h1);
        if (st_ready) begin
            exp_a.push_back(a);
            exp_d.push_back(d);
        end
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic drain_all();
        @(negedge clk);
        wr_rdy = 1'b1;
        for (int t = 0; t < 40 && mem_wr_valid; t++) @(negedge clk);
        wr_rdy = 1'b0;
        chk(mem_wr_valid == 1'b0, "R3 drained", 32'(mem_wr_valid), 32'h0);
    endtask

    // Forwarded load, completes in the request cycle (R4/R5).
    task automatic fwd_load(input logic [31:0] a, input logic [31:0] expd, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        #1;
        chk(ld_done && ld_fwd && !mem_rd_req, {req, " forward handshake"},
            {29'h0, ld_done, ld_fwd, mem_rd_req}, 32'h6);
        chk(ld_data == expd, {req, " forward data"}, ld_data, expd);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Load that must wait for the drain, then read memory (R6/R7/R8).
    task automatic slow_load(input logic [31:0] a, input logic [31:0] expd, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        rd_ack = 1'b0;
        for (int t = 0; t < 3; t++) begin
            #1;
            chk(!ld_done && !mem_rd_req, {req, " held while pending"},
                {30'h0, ld_done, mem_rd_req}, 32'h0);
            chk(st_ready == 1'b0, "R2 store held off by load", 32'(st_ready), 32'h0);
            @(negedge clk);
        end
        wr_rdy = 1'b1;
        for (int t = 0; t < 40 && !mem_rd_req; t++) begin
            @(negedge clk);
            #1;
        end
        chk(mem_rd_req && !mem_wr_valid, "R8 read after writes",
            {30'h0, mem_rd_req, mem_wr_valid}, 32'h2);
        chk(mem_rd_addr == a, "R7 read address", mem_rd_addr, a);
        chk(ld_done == 1'b0, "R7 waits for ack", 32'(ld_done), 32'h0);
        rd_ack = 1'b1;
        #1;
        chk(ld_done && !ld_fwd, "R7 memory completion", {30'h0, ld_done, ld_fwd}, 32'h2);
        chk(ld_data == expd, {req, " memory data"}, ld_data, expd);
        @(negedge clk);
        ld_valid = 1'b0;
        wr_rdy = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE0000 + 32'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_wr_valid == 1'b0, "R1 empty after reset", 32'(mem_wr_valid), 32'h0);
        chk(st_ready == 1'b1, "R1 ready after reset", 32'(st_ready), 32'h1);
        chk(ld_done == 1'b0, "R1 no response after reset", 32'(ld_done), 32'h0);

        // R9: fill to DEPTH with distinct slices, then offer one more.
        for (int i = 0; i < DEPTH; i++)
            push_st(32'h1000 + 32'(i) * 4, 32'h50000000 + 32'(i) * 32'h111);
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h2000; st_data = 32'hDEADBEEF;
        #1;
        chk(st_ready == 1'b0, "R9 full stall", 32'(st_ready), 32'h0);
        @(posedge clk);
        #1 st_valid = 1'b0;
        chk(mem_wr_valid && mem_wr_addr == 32'h1000, "R3 head is oldest",
            mem_wr_addr, 32'h1000);

        // R4: every slot as forwarding source.
        for (int i = 0; i < DEPTH; i++)
            fwd_load(32'h1000 + 32'(i) * 4, 32'h50000000 + 32'(i) * 32'h111, "R4");
        drain_all();

        // R5: n stores to one address, youngest must win.
        for (int n = 2; n <= DEPTH; n++) begin
            for (int j = 0; j < n; j++) push_st(32'h300, 32'(n) * 256 + 32'(j));
            fwd_load(32'h300, 32'(n) * 256 + 32'(n - 1), "R5");
            drain_all();
        end

        // R6: slice match only, differs in bit 10; memory value untouched.
        push_st(32'h104, 32'hAAAA0001);
        slow_load(32'h504, 32'hC0DE0000 + (32'h504 >> 2), "R6");

        // R6: older exact match hidden by a younger slice-only match.
        push_st(32'h108, 32'h00000011);
        push_st(32'h508, 32'h00000022);
        slow_load(32'h108, 32'h00000011, "R6");

        // R7: no match at all, still waits for the queue to empty.
        push_st(32'h200, 32'h12345678);
        push_st(32'h204, 32'h9ABCDEF0);
        slow_load(32'h0F0, 32'hC0DE0000 + (32'h0F0 >> 2), "R7");

        chk(exp_a.size() == 0, "R3 all stores written", 32'(exp_a.size()), 32'h0);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule